// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Code Store

This block keeps two register stages for each of four 12-bit converter channels. A write from the serial decoder lands in the channel's staging register. The code only reaches the live register, which sets the channel's level, when a transfer happens. A transfer happens in one of two ways:

- The shared active-low `load_n` input falls. All four channels then move at once.
- `load_n` is already low when a write executes. The written channel then moves directly.

An active-low `clear_n` input wipes both stages. Clear also blocks every transfer for as long as it is held low.

At each transfer the block captures the range-select input for each channel separately. Because of this, a later change of range select does not disturb a level that was already set. For each channel the block reports the live code, the captured range, and the ideal output level in millivolts. The ideal level is the live code times the full scale, divided by 4096, rounded down. The full scale is 30000 mV when the captured range bit is 1 and 60000 mV when it is 0.

All control inputs are sampled on the rising clock edge. A falling edge means the input was high at the previous rising edge and is low at the current one.

Top module: `quad_code_store`

## Requirements
- R1: While `rst_n` is low, and after its release until a transfer, every staging register, live code, captured range bit and millivolt output is 0.
- R2: A write with `load_n` high changes only the addressed staging register. No live code or captured range bit changes.
- R3: A falling edge of `load_n` with `clear_n` high copies all four staging registers into the live registers at that clock edge. If a write executes in the same cycle, its new code is the one copied.
- R4: A write executed while `load_n` is low (not a falling edge) updates the addressed channel's live code at that edge. The other channels keep their live codes.
- R5: A write with `wr_bcast` = 1 loads all four staging registers. If `load_n` is low, it also loads all four live registers at once.
- R6: A falling edge of `clear_n` sets every staging and live register to 0x000. A later transfer therefore reports code 0.
- R7: While `clear_n` stays low after its falling edge, neither `load_n` edges nor writes with `load_n` low change any live code. Writes still reach the staging registers.
- R8: If a write or a `load_n` falling edge arrives in the same cycle as the `clear_n` falling edge, clear wins and the write is discarded.
- R9: On every transfer each moved channel captures `range_hi` (1 = 30 V scale, 0 = 60 V scale) and reports it on its `range_o` bit.
- R10: `mv_o` for a channel equals floor(code × FS / 4096), where FS is 30000 or 60000 according to the captured range bit. A change of `range_hi` alone never changes `mv_o`.
- R11: `wr_ch` is a binary channel index from 0 to 3. Channel i sits at bits [12i+11:12i] of `code_o` and [16i+15:16i] of `mv_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | A write executes this cycle |
| wr_bcast | input | 1 | The write targets all channels |
| wr_ch | input | 2 | Channel index of a single write |
| wr_code | input | 12 | Code written to the staging register |
| load_n | input | 1 | Active-low transfer strobe |
| clear_n | input | 1 | Active-low clear, falling-edge triggered |
| range_hi | input | 1 | Range select: 1 = 30 V, 0 = 60 V |
| code_o | output | 48 | Live codes, 12 bits per channel |
| range_o | output | 4 | Captured range bit per channel |
| mv_o | output | 64 | Ideal level in mV, 16 bits per channel |

## Verification
Three functions can coincide in one cycle: a clear edge, a channel write, and a transfer (a load edge or a write with load low). The bench provokes this by asserting the `clear_n` falling edge, a write to channel 3 and a `load_n` falling edge on the same clock. A later load edge after clear is released must then show code 0 on every channel. A second coincidence is a load edge together with a write. Here the freshly written code must be the one that reaches the live register. Every cycle is judged against a behavioural model of the two stages.

// File: rtl/quad_code_store.sv
module quad_code_store #(
  parameter int CH       = 4,
  parameter int W        = 12,
  parameter int FS_HI_MV = 30000,
  parameter int FS_LO_MV = 60000,
  localparam int CW  = $clog2(CH),
  localparam int MVW = $clog2(FS_LO_MV + 1),
  localparam int PW  = W + MVW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_bcast,
  input  logic [CW-1:0]     wr_ch,
  input  logic [W-1:0]      wr_code,
  input  logic              load_n,
  input  logic              clear_n,
  input  logic              range_hi,
  output logic [CH*W-1:0]   code_o,
  output logic [CH-1:0]     range_o,
  output logic [CH*MVW-1:0] mv_o
);

  logic ld_q, clr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q  <= 1'b1;
      clr_q <= 1'b1;
    end else begin
      ld_q  <= load_n;
      clr_q <= clear_n;
    end
  end

  wire ld_fall  = ld_q & ~load_n;
  wire clr_fall = clr_q & ~clear_n;

  for (genvar g = 0; g < CH; g++) begin : g_ch
    logic [W-1:0]  stage_q, live_q;
    logic          rng_q;
    logic [PW-1:0] fs, prod;

    wire          hit  = wr_en & (wr_bcast | (wr_ch == CW'(g)));
    wire [W-1:0]  nxt  = hit ? wr_code : stage_q;
    wire          xfer = clear_n & (ld_fall | (~load_n & hit));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
        live_q  <= '0;
        rng_q   <= 1'b0;
      end else if (clr_fall) begin
        stage_q <= '0;
        live_q  <= '0;
      end else begin
        stage_q <= nxt;
        if (xfer) begin
          live_q <= nxt;
          rng_q  <= range_hi;
        end
      end
    end

    assign fs   = rng_q ? PW'(FS_HI_MV) : PW'(FS_LO_MV);
    assign prod = PW'(live_q) * fs;
    assign code_o[g*W +: W]     = live_q;
    assign range_o[g]           = rng_q;
    assign mv_o[g*MVW +: MVW]   = MVW'(prod >> W);

    p_sync_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_n && !load_n && wr_en && !wr_bcast && wr_ch == CW'(g))
      |=> (code_o[g*W +: W] == $past(wr_code)));
  end

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && clear_n) |=> $stable(code_o));

  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_n && clr_q) |=> (code_o == '0));

  p_clear_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_n && !clr_q) |=> $stable(code_o));

  p_range_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && clear_n) |=> ($stable(range_o) && $stable(mv_o)));

endmodule

// File: tb/quad_code_store_bench.sv
module quad_code_store_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, wr_bcast = 0, load_n = 1, clear_n = 1, range_hi = 0;
  logic [1:0]  wr_ch = 0;
  logic [11:0] wr_code = 0;
  logic [47:0] code_o;
  logic [3:0]  range_o;
  logic [63:0] mv_o;

  int n_chk = 0, n_bad = 0;
  string cur = "R1";

  int m_in[4], m_out[4], m_rg[4];
  bit pl, pc;

  quad_code_store u_quad_code_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bcast(wr_bcast), .wr_ch(wr_ch),
    .wr_code(wr_code), .load_n(load_n), .clear_n(clear_n), .range_hi(range_hi),
    .code_o(code_o), .range_o(range_o), .mv_o(mv_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_in[i]) begin m_in[i] = 0; m_out[i] = 0; m_rg[i] = 0; end
      pl = 1; pc = 1;
    end else begin
      bit fl, fc, hit;
      fl = pl && !load_n;
      fc = pc && !clear_n;
      for (int i = 0; i < 4; i++) begin
        hit = wr_en && (wr_bcast || wr_ch == i);
        if (fc) begin
          m_in[i] = 0; m_out[i] = 0;
        end else begin
          if (hit) m_in[i] = wr_code;
          if (clear_n && (fl || (!load_n && hit))) begin
            m_out[i] = m_in[i]; m_rg[i] = range_hi;
          end
        end
      end
      pl = load_n; pc = clear_n;
    end
  end

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int code_of(int i); return code_o[i*12 +: 12]; endfunction
  function automatic int mv_of(int i);   return mv_o[i*16 +: 16];   endfunction

  task automatic compare();
    for (int i = 0; i < 4; i++) begin
      chk({cur, " code"}, code_of(i), m_out[i]);
      chk({cur, " range"}, range_o[i], m_rg[i]);
      chk({cur, " mV R10"}, mv_of(i), (m_out[i] * (m_rg[i] ? 30000 : 60000)) / 4096);
    end
  endtask

  task automatic step(bit en, bit bc, int ch, int code, bit ld, bit clr, bit rg);
    wr_en = en; wr_bcast = bc; wr_ch = 2'(ch); wr_code = 12'(code);
    load_n = ld; clear_n = clr; range_hi = rg;
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1;
    @(negedge clk);
    cur = "R1";
    compare();
    for (int i = 0; i < 4; i++) chk("R1 reset code", code_of(i), 0);

    cur = "R2";
    step(1, 0, 1, 'h800, 1, 1, 1);
    step(1, 0, 0, 'hFFF, 1, 1, 1);
    step(1, 0, 2, 'h123, 1, 1, 1);
    step(1, 0, 3, 'h001, 1, 1, 1);
    chk("R2 staging only", code_of(1), 0);

    cur = "R3";
    step(0, 0, 0, 0, 0, 1, 1);
    chk("R3 load edge ch0", code_of(0), 'hFFF);
    chk("R11 load edge ch1", code_of(1), 'h800);
    chk("R3 load edge ch3", code_of(3), 'h001);
    chk("R9 range captured", range_o, 4'b1111);
    chk("R10 mV 30V half", mv_of(1), 15000);

    cur = "R4";
    step(1, 0, 2, 'h456, 0, 1, 1);
    chk("R4 sync ch2", code_of(2), 'h456);
    chk("R4 others kept", code_of(0), 'hFFF);

    cur = "R10";
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R10 range change no effect", mv_of(1), 15000);

    cur = "R9";
    step(1, 0, 0, 'hFFF, 0, 1, 0);
    chk("R9 range 60V captured", range_o[0], 0);
    chk("R10 mV full scale 60V", mv_of(0), 59985);
    chk("R9 other range kept", range_o[1], 1);

    cur = "R5";
    step(1, 1, 0, 'h0AA, 0, 1, 1);
    for (int i = 0; i < 4; i++) chk("R5 broadcast sync", code_of(i), 'h0AA);
    step(0, 0, 0, 0, 1, 1, 1);
    step(1, 1, 0, 'h111, 1, 1, 1);
    chk("R2 broadcast staged", code_of(3), 'h0AA);

    cur = "R3";
    step(1, 0, 2, 'h5A5, 0, 1, 0);
    chk("R3 edge with write", code_of(2), 'h5A5);
    chk("R5 staged broadcast moved", code_of(0), 'h111);

    cur = "R6";
    step(0, 0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 4; i++) chk("R6 clear", code_of(i), 0);

    cur = "R7";
    step(1, 0, 0, 'h777, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R7 blocked", code_of(0), 0);
    step(0, 0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R7 staging kept write", code_of(0), 'h777);
    chk("R6 staging wiped", code_of(1), 0);

    cur = "R8";
    step(0, 0, 0, 0, 1, 1, 1);
    step(1, 0, 3, 'h999, 0, 0, 1);
    chk("R8 clear wins", code_of(3), 0);
    step(0, 0, 0, 0, 1, 1, 1);
    step(0, 0, 0, 0, 0, 1, 1);
    chk("R8 write discarded", code_of(3), 0);
    step(0, 0, 0, 0, 1, 1, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule